// File: doc/BRIEF.md
# Per-Pin GPIO Interrupt Detector

This block watches a bank of general-purpose pins and turns chosen pin activity into interrupt requests. Each pin has its own setup. It can be edge-sensed or level-sensed. An edge-sensed pin reacts either to any change or to one chosen direction. A level-sensed pin reacts while it sits at a chosen level. Each pin also has an enable bit that decides whether its status may reach the shared interrupt line.

Pin levels first pass through a short synchronizer. The block then compares each synchronized sample with the one taken a cycle earlier. Every detection sets a sticky raw status bit. Software clears a bit by pulsing a one on the matching bit of the clear input. The block drives the raw status, the status gated by the enable vector, and one combined interrupt output. The pin direction vector suppresses edge detection on pins that the chip drives as outputs.

Top module: `gpio_irq_detector`

## Requirements
- R1: After reset the raw status, the masked status and the interrupt output are all 0. The synchronizer and the stored previous sample also start at 0.
- R2: When a pin's sense bit is 0 (edge mode) and its any-edge bit is 1, both a rising change and a falling change of the synchronized level set its raw status bit.
- R3: When a pin is in edge mode and its any-edge bit is 0, only one direction sets its status. A polarity bit of 1 selects rising changes (new level 1). A polarity bit of 0 selects falling changes (new level 0).
- R4: When a pin's sense bit is 1 (level mode), its status bit is set on every cycle in which the synchronized level equals its polarity bit. This holds for both polarities and for either direction setting.
- R5: A pin whose direction bit is 1 (driven as an output) produces no edge detection, whatever its level does.
- R6: Raw status bits are sticky. A 1 on a bit of the clear input clears that status bit at the next clock edge. A 0 on a clear bit leaves that status bit unchanged.
- R7: The masked status equals the raw status AND the enable vector. The interrupt output is 1 exactly when some masked status bit is 1.
- R8: If a clear and a new detection hit the same pin at the same clock edge, the detection wins and the bit remains set.
- R9: A pin change driven before clock edge k shows in the raw status after edge k+SYNC_STAGES, and not earlier. This gives 3 edges with the default of 2 stages.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_i | input | NPINS | Raw pin levels (asynchronous) |
| drive_out_i | input | NPINS | Pin direction, 1 = output pin (no edge detection) |
| sense_level_i | input | NPINS | 0 = edge mode, 1 = level mode |
| any_edge_i | input | NPINS | Edge mode: 1 = react to both directions |
| polarity_i | input | NPINS | 1 = rising / high, 0 = falling / low |
| enable_i | input | NPINS | Per-pin interrupt enable |
| clear_i | input | NPINS | Write-one-to-clear pulse for raw status |
| raw_status_o | output | NPINS | Sticky raw status |
| masked_status_o | output | NPINS | Raw status AND enable |
| irq_o | output | 1 | OR of the masked status |

## Verification
The bench builds the block with NPINS = 8 and SYNC_STAGES = 2. With eight pins, one stimulus word can put pins in different modes at the same time: rising-only next to falling-only, output pins next to input pins, and level next to edge. Two stages fix the latency at three edges. This lets the bench pulse a clear on exactly the edge where a detection lands, which tests the priority between clear and detection. A queue-based model tracks every cycle, and directed checks pin down the latency boundary and the clear-versus-detection priority.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

    typedef enum logic {
        SENSE_EDGE  = 1'b0,
        SENSE_LEVEL = 1'b1
    } sense_e;

    // Decide whether one pin reports an event this cycle.
    function automatic logic pin_hit(
        sense_e mode,
        logic   any_edge,
        logic   polarity,
        logic   is_input,
        logic   cur,
        logic   prev
    );
        logic hit;
        hit = 1'b0;
        if (mode == SENSE_LEVEL) begin
            hit = (cur == polarity);
        end else if (is_input && (cur != prev)) begin
            hit = any_edge ? 1'b1 : (cur == polarity);
        end
        return hit;
    endfunction

endpackage

// File: rtl/gpio_irq_sync.sv
module gpio_irq_sync #(
    parameter int WIDTH  = 8,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);
    localparam int LAST = STAGES - 1;

    logic [WIDTH-1:0] chain_d [STAGES];
    logic [WIDTH-1:0] chain_q [STAGES];

    always_comb begin
        chain_d[0] = async_i;
        for (int k = 1; k < STAGES; k++) begin
            chain_d[k] = chain_q[k-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int k = 0; k < STAGES; k++) chain_q[k] <= '0;
        end else begin
            for (int k = 0; k < STAGES; k++) chain_q[k] <= chain_d[k];
        end
    end

    assign sync_o = chain_q[LAST];
endmodule

// File: rtl/gpio_irq_event.sv
module gpio_irq_event
    import gpio_irq_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0] cur_i,
    input  logic [WIDTH-1:0] prev_i,
    input  logic [WIDTH-1:0] drive_out_i,
    input  logic [WIDTH-1:0] sense_level_i,
    input  logic [WIDTH-1:0] any_edge_i,
    input  logic [WIDTH-1:0] polarity_i,
    output logic [WIDTH-1:0] hit_o
);
    for (genvar g = 0; g < WIDTH; g++) begin : g_pin
        assign hit_o[g] = pin_hit(sense_e'(sense_level_i[g]), any_edge_i[g],
                                  polarity_i[g], ~drive_out_i[g],
                                  cur_i[g], prev_i[g]);
    end
endmodule

// File: rtl/gpio_irq_status.sv
module gpio_irq_status #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] sample_i,
    input  logic [WIDTH-1:0] hit_i,
    input  logic [WIDTH-1:0] clear_i,
    output logic [WIDTH-1:0] prev_o,
    output logic [WIDTH-1:0] status_o
);
    typedef struct packed {
        logic [WIDTH-1:0] prev;
        logic [WIDTH-1:0] status;
    } state_t;

    state_t st_d, st_q;

    always_comb begin
        st_d        = st_q;
        st_d.prev   = sample_i;
        // detection is OR-ed after the clear so it takes priority
        st_d.status = (st_q.status & ~clear_i) | hit_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign prev_o   = st_q.prev;
    assign status_o = st_q.status;
endmodule

// File: rtl/gpio_irq_detector.sv
module gpio_irq_detector #(
    parameter int NPINS       = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NPINS-1:0] pin_i,
    input  logic [NPINS-1:0] drive_out_i,
    input  logic [NPINS-1:0] sense_level_i,
    input  logic [NPINS-1:0] any_edge_i,
    input  logic [NPINS-1:0] polarity_i,
    input  logic [NPINS-1:0] enable_i,
    input  logic [NPINS-1:0] clear_i,
    output logic [NPINS-1:0] raw_status_o,
    output logic [NPINS-1:0] masked_status_o,
    output logic             irq_o
);
    logic [NPINS-1:0] sync_lvl;
    logic [NPINS-1:0] prev_lvl;
    logic [NPINS-1:0] hit;
    logic [NPINS-1:0] status;

    gpio_irq_sync #(.WIDTH(NPINS), .STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (pin_i),
        .sync_o  (sync_lvl)
    );

    gpio_irq_event #(.WIDTH(NPINS)) u_event (
        .cur_i         (sync_lvl),
        .prev_i        (prev_lvl),
        .drive_out_i   (drive_out_i),
        .sense_level_i (sense_level_i),
        .any_edge_i    (any_edge_i),
        .polarity_i    (polarity_i),
        .hit_o         (hit)
    );

    gpio_irq_status #(.WIDTH(NPINS)) u_status (
        .clk      (clk),
        .rst_n    (rst_n),
        .sample_i (sync_lvl),
        .hit_i    (hit),
        .clear_i  (clear_i),
        .prev_o   (prev_lvl),
        .status_o (status)
    );

    assign raw_status_o    = status;
    assign masked_status_o = status & enable_i;
    assign irq_o           = |masked_status_o;
endmodule

// File: rtl/gpio_irq_detector_chk.sv
module gpio_irq_detector_chk #(
    parameter int NPINS = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic [NPINS-1:0] drive_out_i,
    input logic [NPINS-1:0] sense_level_i,
    input logic [NPINS-1:0] enable_i,
    input logic [NPINS-1:0] clear_i,
    input logic [NPINS-1:0] raw_status_o,
    input logic [NPINS-1:0] masked_status_o,
    input logic             irq_o
);
    assert_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (($past(raw_status_o) & ~$past(clear_i) & ~raw_status_o) == '0));

    assert_output_pin_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ((raw_status_o & ~$past(raw_status_o)
          & $past(drive_out_i) & ~$past(sense_level_i)) == '0));

    assert_irq_source_R7: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> ((raw_status_o & enable_i) != '0));

    assert_irq_present_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ((raw_status_o & enable_i) != '0) |-> irq_o);

    assert_masked_subset_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ((masked_status_o & ~raw_status_o) == '0));
endmodule

bind gpio_irq_detector gpio_irq_detector_chk #(.NPINS(NPINS)) u_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .drive_out_i     (drive_out_i),
    .sense_level_i   (sense_level_i),
    .enable_i        (enable_i),
    .clear_i         (clear_i),
    .raw_status_o    (raw_status_o),
    .masked_status_o (masked_status_o),
    .irq_o           (irq_o)
);

// File: tb/gpio_irq_detector_test.sv
module gpio_irq_detector_test;
    localparam int N    = 8;
    localparam int SYNC = 2;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [N-1:0] pin = '0, dir = '0, lvl = '0, anye = '0, pol = '0, en = '0, clr = '0;
    logic [N-1:0] raw, masked;
    logic         irq;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    string cur_req = "R1";

    gpio_irq_detector #(.NPINS(N), .SYNC_STAGES(SYNC)) uut (
        .clk(clk), .rst_n(rst_n), .pin_i(pin), .drive_out_i(dir),
        .sense_level_i(lvl), .any_edge_i(anye), .polarity_i(pol),
        .enable_i(en), .clear_i(clr), .raw_status_o(raw),
        .masked_status_o(masked), .irq_o(irq)
    );

    always #5 clk = ~clk;

    // behavioural reference
    logic [N-1:0] pipe [$];
    logic [N-1:0] m_prev = '0;
    logic [N-1:0] m_stat = '0;

    initial for (int k = 0; k < SYNC; k++) pipe.push_back('0);

    always @(posedge clk) begin
        if (!rst_n) begin
            pipe = {};
            for (int k = 0; k < SYNC; k++) pipe.push_back('0);
            m_prev = '0;
            m_stat = '0;
        end else begin
            logic [N-1:0] s;
            logic [N-1:0] ev;
            s = pipe[0];
            for (int b = 0; b < N; b++) begin
                if (lvl[b])                        ev[b] = (s[b] == pol[b]);
                else if (dir[b] || s[b] == m_prev[b]) ev[b] = 1'b0;
                else if (anye[b])                  ev[b] = 1'b1;
                else                               ev[b] = (s[b] == pol[b]);
            end
            m_stat = (m_stat & ~clr) | ev;
            m_prev = s;
            void'(pipe.pop_front());
            pipe.push_back(pin);
        end
        #2;
        if (rst_n) begin
            checks++;
            if (raw !== m_stat || masked !== (m_stat & en) || irq !== |(m_stat & en)) begin
                fails++;
                $display("FAIL %s cycle %0d: raw=%h masked=%h irq=%b expected raw=%h masked=%h irq=%b",
                         cur_req, cyc, raw, masked, irq, m_stat, m_stat & en, |(m_stat & en));
            end
        end
    end

    task automatic chk(string req, logic [N-1:0] act, logic [N-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic tick(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic clear_bits(logic [N-1:0] m);
        clr = m;
        tick(1);
        clr = '0;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        tick(3);
        rst_n = 1'b1;
        tick(1);
        chk("R1 raw", raw, 8'h00);
        chk("R1 irq", {7'b0, irq}, 8'h00);

        // R2: any-edge mode
        cur_req = "R2";
        anye = 8'hFF; en = 8'hFF;
        pin = 8'h05;
        tick(2);
        chk("R9 not before latency", raw, 8'h00);
        tick(1);
        chk("R9/R2 rising any-edge", raw, 8'h05);
        clear_bits(8'hFF);
        chk("R6 clear all", raw, 8'h00);
        pin = 8'h00;
        tick(3);
        chk("R2 falling any-edge", raw, 8'h05);

        // R3: single direction
        cur_req = "R3";
        anye = 8'h00; pol = 8'h01;
        clear_bits(8'hFF);
        pin = 8'h03;
        tick(3);
        chk("R3 rising only on pin0", raw, 8'h01);
        clear_bits(8'hFF);
        pin = 8'h00;
        tick(3);
        chk("R3 falling only on pin1", raw, 8'h02);

        // R7: masking
        cur_req = "R7";
        en = 8'h00; tick(1);
        chk("R7 masked with enable 0", masked, 8'h00);
        chk("R7 irq low with enable 0", {7'b0, irq}, 8'h00);
        chk("R6 raw kept while masked", raw, 8'h02);
        en = 8'h02; tick(1);
        chk("R7 masked with enable bit1", masked, 8'h02);
        chk("R7 irq high", {7'b0, irq}, 8'h01);
        en = 8'hFD; tick(1);
        chk("R7 irq low other enables", {7'b0, irq}, 8'h00);
        en = 8'hFF;

        // R6: clear selectivity
        cur_req = "R6";
        clear_bits(8'h00);
        chk("R6 zero clear no effect", raw, 8'h02);
        clear_bits(8'h01);
        chk("R6 other bit clear no effect", raw, 8'h02);
        clear_bits(8'h02);
        chk("R6 write-one clears", raw, 8'h00);

        // R5: output pins ignored for edges
        cur_req = "R5";
        dir = 8'hF0;
        pin = 8'hF0;
        tick(4);
        chk("R5 output pins no edge", raw, 8'h00);
        dir = 8'h00;
        pin = 8'hE0;
        tick(3);
        chk("R5 input pin4 falling", raw, 8'h10);
        clear_bits(8'hFF);
        pin = 8'h00;
        tick(3);
        chk("R5 pins 5-7 falling as inputs", raw, 8'hE0);
        clear_bits(8'hFF);

        // R8: detection beats clear on the same edge
        cur_req = "R8";
        anye = 8'hFF;
        pin = 8'h01;
        tick(2);
        clr = 8'h01;
        tick(1);
        clr = 8'h00;
        chk("R8 detection wins over clear", raw, 8'h01);
        clear_bits(8'hFF);
        chk("R8 later clear works", raw, 8'h00);

        // R4: level mode
        cur_req = "R4";
        lvl = 8'h04; pol = 8'h04;
        pin = 8'h05;
        tick(3);
        chk("R4 high level sets", raw, 8'h04);
        clear_bits(8'h04);
        chk("R4/R8 level re-sets over clear", raw, 8'h04);
        pin = 8'h01;
        tick(3);
        clear_bits(8'h04);
        chk("R4 clear after level gone", raw, 8'h00);
        tick(2);
        chk("R4 stays clear", raw, 8'h00);
        pol = 8'h00;
        tick(1);
        chk("R4 low level sets", raw, 8'h04);
        tick(2);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule